// File: doc/BRIEF.md
# DMA Channel Trigger and Burst Controller

This block sits beside one DMA channel and decides when that channel may move data and how many items it moves each time. A trigger can come from three places: a hardware trigger line, a software trigger pulse, or a set-trigger strobe. The hardware line can be sensed on an edge or on a level, with either polarity. An optional peripheral request line can also gate the channel. When the channel is triggered, allowed to run and has no burst outstanding, the block gives the transfer engine a one-cycle `go` pulse together with an item count. The count is either one item or a burst of 2^n items. The engine then reports each item it moves on `item_done`.

The block also counts moved items in blocks of 2^n. For the source side and for the destination side it can flag the item that ends such a block, so that the engine reloads the address it had at the start of the block instead of advancing it. The trigger flag and the channel priority field are brought out for status reporting and for arbitration elsewhere. Descriptor fetch and the data path are outside this block.

Top module: `trigburst_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the first cycle after it, `go`, `trig_flag`, `src_wrap` and `dst_wrap` are 0 and `go_count` is 0.
- R2: If `cfg_word[1]` is 0, or if `cfg_word[5]` is 0, a `sw_trig` or `set_trig` pulse sets `trig_flag` at the next clock edge. The flag then holds until an edge where `desc_done` and `desc_clr_trig` are both 1. `desc_done` alone does not clear it. A set and a clear at the same edge leave the flag set.
- R3: Edge mode is `cfg_word[1]`=1 with `cfg_word[5]`=0. In this mode the active edge of `hw_trig` sets `trig_flag` at the clock edge that samples the new level. The active edge is rising when `cfg_word[4]`=1 and falling when it is 0. The opposite edge has no effect, and the flag stays set after the input returns.
- R4: Level mode is `cfg_word[1]`=1 with `cfg_word[5]`=1. In this mode `trig_flag` equals (`hw_trig`==`cfg_word[4]`) as sampled one clock earlier. `sw_trig`, `set_trig` and the descriptor clear have no effect in this mode.
- R5: `go` is a one-cycle pulse. It rises one clock after a cycle in which `trig_flag` is 1, no burst is outstanding, and either `cfg_word[0]` is 0 or `periph_req` is 1.
- R6: With `go`, `go_count` is 1 when `cfg_word[6]`=0. When `cfg_word[6]`=1 it is 2^n, where n is `cfg_word[11:8]` clamped to 10 (at most 1024).
- R7: After `go`, no new `go` is issued until `go_count` `item_done` pulses have been taken or `desc_done` arrives. `item_done` while no burst is outstanding is ignored. If `trig_flag` is still set, the next `go` follows one clock after the burst ends.
- R8: Taken items are counted modulo 2^n, with n as in R6 in either mode. The counter restarts on `desc_done`. `src_wrap` (enabled by `cfg_word[14]`) and `dst_wrap` (enabled by `cfg_word[15]`) are high in the same cycle as the `item_done` that completes a block of 2^n.
- R9: `chan_prio` equals `cfg_word[18:16]`, where 0 is the highest priority.
- R10: A `hw_trig` level held steady across reset release is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Channel configuration word (fields in R2 to R9) |
| periph_req | input | 1 | Peripheral request, used when cfg_word[0]=1 |
| hw_trig | input | 1 | Hardware trigger input, synchronous to clk |
| sw_trig | input | 1 | Software trigger pulse |
| set_trig | input | 1 | Set-trigger strobe |
| item_done | input | 1 | Engine has moved one item |
| desc_done | input | 1 | Engine has finished the current descriptor |
| desc_clr_trig | input | 1 | Qualifies desc_done: clear the trigger flag |
| go | output | 1 | One-cycle start pulse to the engine |
| go_count | output | 11 | Items to move for this go |
| trig_flag | output | 1 | Trigger currently set |
| src_wrap | output | 1 | Reload source address to block start after this item |
| dst_wrap | output | 1 | Reload destination address to block start after this item |
| chan_prio | output | 3 | Channel priority field |

## Verification
A trigger event sampled at edge k shows up on `trig_flag` right after edge k. The `go` pulse and its `go_count` follow one edge later, at k+1. A burst that ends on the `item_done` taken at edge m lets the next `go` appear after edge m+1. The wrap outputs are combinational, so they are valid in the same cycle as `item_done`. The bench drives every input just after a falling edge. It reads registered results at the next falling edge, and reads the wrap outputs 1 ns after driving `item_done`. Each check therefore lands exactly in the cycle where the result is due, and the bench also checks that no `go` appears a cycle early.

// File: rtl/trigburst_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions and the decoded channel configuration.
// Assumes a 32-bit configuration word whose bit positions the engine side
// and software decode the same way.
package trigburst_pkg;
    localparam int CFG_W    = 32;
    localparam int POW_W    = 4;
    localparam int B_GATE   = 0;
    localparam int B_HWEN   = 1;
    localparam int B_POL    = 4;
    localparam int B_LEVEL  = 5;
    localparam int B_BURST  = 6;
    localparam int B_POW    = 8;
    localparam int B_SWRAP  = 14;
    localparam int B_DWRAP  = 15;
    localparam int B_PRIO   = 16;

    typedef struct packed {
        logic             gate_en;
        logic             hw_en;
        logic             pol_high;
        logic             level;
        logic             burst;
        logic [POW_W-1:0] pow;
        logic             src_wrap_en;
        logic             dst_wrap_en;
    } chan_cfg_t;
endpackage

// File: rtl/trigburst_trig.sv
`timescale 1ns/1ps
// Trigger flag unit: holds the channel trigger flag.
// In level mode the flag follows the qualified input one cycle later.
// Otherwise, software pulses, set strobes and active hardware edges latch
// the flag, and the descriptor clear drops it (a set beats a clear).
// Assumes hw_trig is already synchronous to clk.
module trigburst_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_en,
    input  logic pol_high,
    input  logic level,
    input  logic hw_trig,
    input  logic sw_trig,
    input  logic set_trig,
    input  logic clr_req,
    output logic trig_flag
);
    logic hw_prev;
    logic asserted;
    logic act_edge;
    logic set_evt;

    // Qualify the input and find an active-polarity edge.
    always_comb begin
        asserted = (hw_trig == pol_high);
        act_edge = hw_en && asserted && (hw_prev != pol_high);
        set_evt  = sw_trig || set_trig || act_edge;
    end

    // Previous input level (loaded in reset too) and the trigger flag.
    always_ff @(posedge clk) begin
        hw_prev <= hw_trig;
        if (!rst_n) begin
            trig_flag <= 1'b0;
        end else if (hw_en && level) begin
            trig_flag <= asserted;
        end else if (set_evt) begin
            trig_flag <= 1'b1;
        end else if (clr_req) begin
            trig_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/trigburst_seq.sv
`timescale 1ns/1ps
// Burst sequencer: issues a one-cycle go with an item count when the
// channel is triggered, allowed and idle. It then counts item_done pulses
// down to zero before it can launch again. desc_done abandons the burst.
// Assumes pow is already clamped to MAX_POW.
module trigburst_seq #(
    parameter int MAX_POW = 10,
    localparam int CNT_W  = MAX_POW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_flag,
    input  logic             req_ok,
    input  logic             burst,
    input  logic [3:0]       pow,
    input  logic             item_done,
    input  logic             desc_done,
    output logic             go,
    output logic [CNT_W-1:0] go_count,
    output logic             busy
);
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] size;
    logic             launch;

    // Items per go and the launch condition.
    always_comb begin
        size   = burst ? (CNT_W'(1) << pow) : CNT_W'(1);
        busy   = (rem != '0);
        launch = trig_flag && req_ok && !busy;
    end

    // Go pulse, count register and remaining-item counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go       <= 1'b0;
            go_count <= '0;
            rem      <= '0;
        end else begin
            go <= launch;
            if (launch) begin
                go_count <= size;
                rem      <= size;
            end else if (desc_done) begin
                rem <= '0;
            end else if (item_done && busy) begin
                rem <= rem - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/trigburst_wrap.sv
`timescale 1ns/1ps
// Wrap tracker: counts taken items modulo 2^pow and flags, for each address
// port that enables it, the item that closes a block. The engine then
// reloads that port's block-start address. Assumes item_ok is only high
// while a burst is outstanding.
module trigburst_wrap #(
    parameter int MAX_POW = 10,
    parameter int NPORT   = 2,
    localparam int CNT_W  = MAX_POW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             item_ok,
    input  logic             desc_done,
    input  logic [3:0]       pow,
    input  logic [NPORT-1:0] wrap_en,
    output logic [NPORT-1:0] wrap_hit
);
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] blk_last;
    logic             at_end;

    // Index of the last item in a block.
    always_comb begin
        blk_last = (CNT_W'(1) << pow) - CNT_W'(1);
        at_end   = (idx >= blk_last);
    end

    // Position inside the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (desc_done) begin
            idx <= '0;
        end else if (item_ok) begin
            idx <= at_end ? '0 : idx + CNT_W'(1);
        end
    end

    // One wrap flag per address port.
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign wrap_hit[g] = item_ok && at_end && wrap_en[g];
    end
endmodule

// File: rtl/trigburst_ctrl.sv
`timescale 1ns/1ps
// Top: per-channel trigger and burst controller. Decodes the configuration
// word, gates launches on the peripheral request, and ties together the
// trigger unit, burst sequencer and wrap tracker. Assumes all inputs are
// synchronous to clk.
module trigburst_ctrl #(
    parameter int MAX_POW = 10,
    parameter int PRIO_W  = 3,
    localparam int CNT_W  = MAX_POW + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [trigburst_pkg::CFG_W-1:0]   cfg_word,
    input  logic                              periph_req,
    input  logic                              hw_trig,
    input  logic                              sw_trig,
    input  logic                              set_trig,
    input  logic                              item_done,
    input  logic                              desc_done,
    input  logic                              desc_clr_trig,
    output logic                              go,
    output logic [CNT_W-1:0]                  go_count,
    output logic                              trig_flag,
    output logic                              src_wrap,
    output logic                              dst_wrap,
    output logic [PRIO_W-1:0]                 chan_prio
);
    import trigburst_pkg::*;

    chan_cfg_t  cfg;
    logic       req_ok;
    logic       busy;
    logic [1:0] wrap_hit;
    logic       cfg_unused;

    // Field decode with the burst power clamped to MAX_POW.
    always_comb begin
        cfg.gate_en     = cfg_word[B_GATE];
        cfg.hw_en       = cfg_word[B_HWEN];
        cfg.pol_high    = cfg_word[B_POL];
        cfg.level       = cfg_word[B_LEVEL];
        cfg.burst       = cfg_word[B_BURST];
        cfg.pow         = cfg_word[B_POW +: POW_W];
        if (cfg.pow > POW_W'(MAX_POW)) cfg.pow = POW_W'(MAX_POW);
        cfg.src_wrap_en = cfg_word[B_SWRAP];
        cfg.dst_wrap_en = cfg_word[B_DWRAP];
        req_ok          = !cfg.gate_en || periph_req;
    end

    assign chan_prio  = cfg_word[B_PRIO +: PRIO_W];
    assign cfg_unused = ^{cfg_word[3:2], cfg_word[7], cfg_word[13:12],
                          cfg_word[CFG_W-1:B_PRIO+PRIO_W]};

    trigburst_trig u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_en     (cfg.hw_en),
        .pol_high  (cfg.pol_high),
        .level     (cfg.level),
        .hw_trig   (hw_trig),
        .sw_trig   (sw_trig),
        .set_trig  (set_trig),
        .clr_req   (desc_done && desc_clr_trig),
        .trig_flag (trig_flag)
    );

    trigburst_seq #(.MAX_POW(MAX_POW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_flag (trig_flag),
        .req_ok    (req_ok),
        .burst     (cfg.burst),
        .pow       (cfg.pow),
        .item_done (item_done),
        .desc_done (desc_done),
        .go        (go),
        .go_count  (go_count),
        .busy      (busy)
    );

    trigburst_wrap #(.MAX_POW(MAX_POW), .NPORT(2)) u_wrap (
        .clk       (clk),
        .rst_n     (rst_n),
        .item_ok   (item_done && busy),
        .desc_done (desc_done),
        .pow       (cfg.pow),
        .wrap_en   ({cfg.dst_wrap_en, cfg.src_wrap_en}),
        .wrap_hit  (wrap_hit)
    );

    assign src_wrap = wrap_hit[0];
    assign dst_wrap = wrap_hit[1];
endmodule

// File: rtl/trigburst_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the controller's ports, bound to the top.
module trigburst_chk #(
    parameter int MAX_POW = 10,
    localparam int CNT_W  = MAX_POW + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [CNT_W-1:0] go_count,
    input logic             trig_flag,
    input logic             item_done,
    input logic             src_wrap,
    input logic             dst_wrap,
    input logic             hw_trig,
    input logic             gate_en,
    input logic             periph_req,
    input logic             hw_en,
    input logic             level_mode,
    input logic             pol_high
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(1) << MAX_POW;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!go && !trig_flag));

    // R5
    go_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    // R5
    go_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> ($past(trig_flag) && $past(!gate_en || periph_req)));

    // R6
    go_count_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (($countones(go_count) == 1) && (go_count <= MAX_CNT)));

    // R8
    wrap_with_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wrap || dst_wrap) |-> item_done);

    // R4
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hw_en && level_mode))
            |-> (trig_flag == $past(hw_trig == pol_high)));
endmodule

bind trigburst_ctrl trigburst_chk #(.MAX_POW(MAX_POW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_count   (go_count),
    .trig_flag  (trig_flag),
    .item_done  (item_done),
    .src_wrap   (src_wrap),
    .dst_wrap   (dst_wrap),
    .hw_trig    (hw_trig),
    .gate_en    (cfg_word[0]),
    .periph_req (periph_req),
    .hw_en      (cfg_word[1]),
    .level_mode (cfg_word[5]),
    .pol_high   (cfg_word[4])
);

// File: tb/trigburst_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; inputs change after falling edges.
module trigburst_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        periph_req = 1'b0, hw_trig = 1'b0, sw_trig = 1'b0, set_trig = 1'b0;
    logic        item_done = 1'b0, desc_done = 1'b0, desc_clr_trig = 1'b0;
    logic        go, trig_flag, src_wrap, dst_wrap;
    logic [10:0] go_count;
    logic [2:0]  chan_prio;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    trigburst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .periph_req(periph_req),
        .hw_trig(hw_trig), .sw_trig(sw_trig), .set_trig(set_trig),
        .item_done(item_done), .desc_done(desc_done), .desc_clr_trig(desc_clr_trig),
        .go(go), .go_count(go_count), .trig_flag(trig_flag),
        .src_wrap(src_wrap), .dst_wrap(dst_wrap), .chan_prio(chan_prio)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reset_dut(input logic [31:0] c, input logic h);
        rst_n = 1'b0; cfg_word = c; hw_trig = h;
        periph_req = 0; sw_trig = 0; set_trig = 0;
        item_done = 0; desc_done = 0; desc_clr_trig = 0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_word = 32'h0; sw_trig = 1'b1;
        repeat (3) tick();
        chk("R1 go in reset", go, 0);
        chk("R1 flag in reset", trig_flag, 0);
        chk("R1 count in reset", go_count, 0);
        chk("R1 wraps in reset", {src_wrap, dst_wrap}, 0);
        sw_trig = 1'b0;
    endtask

    task automatic t_sw_single();
        reset_dut(32'h0, 1'b0);
        pulse_sw();
        chk("R2 flag after sw", trig_flag, 1);
        chk("R5 no early go", go, 0);
        tick();
        chk("R5 go pulse", go, 1);
        chk("R6 single count", go_count, 1);
        tick();
        chk("R5 go one cycle", go, 0);
        tick();
        chk("R7 no go while busy", go, 0);
        item_done = 1'b1; tick(); item_done = 1'b0;
        chk("R7 no go on last item edge", go, 0);
        tick();
        chk("R7 relaunch while flag set", go, 1);
        item_done = 1'b1; desc_done = 1'b1; desc_clr_trig = 1'b1; tick();
        item_done = 1'b0; desc_done = 1'b0; desc_clr_trig = 1'b0;
        chk("R2 clear by descriptor", trig_flag, 0);
        tick();
        chk("R5 no go after clear", go, 0);
    endtask

    task automatic t_set_strobe();
        reset_dut(32'h0, 1'b0);
        set_trig = 1'b1; desc_done = 1'b1; desc_clr_trig = 1'b1; tick();
        set_trig = 1'b0; desc_done = 1'b0; desc_clr_trig = 1'b0;
        chk("R2 set beats clear", trig_flag, 1);
        desc_done = 1'b1; tick(); desc_done = 1'b0;
        chk("R2 done without clear keeps flag", trig_flag, 1);
    endtask

    task automatic t_burst();
        reset_dut(32'h0000_0340, 1'b0);
        pulse_sw(); tick();
        chk("R6 burst count 8", go_count, 8);
        chk("R5 burst go", go, 1);
        for (int i = 0; i < 8; i++) begin
            item_done = 1'b1; tick(); item_done = 1'b0;
            chk("R7 no go inside burst", go, 0);
        end
        tick();
        chk("R7 go after full burst", go, 1);
    endtask

    task automatic t_clamp();
        reset_dut(32'h0000_0C40, 1'b0);
        pulse_sw(); tick();
        chk("R6 clamped count", go_count, 1024);
    endtask

    task automatic t_edge_rise();
        reset_dut(32'h0000_0012, 1'b1);
        tick();
        chk("R10 no edge at reset release", trig_flag, 0);
        hw_trig = 1'b0; tick();
        chk("R3 falling ignored in rising mode", trig_flag, 0);
        hw_trig = 1'b1; tick();
        chk("R3 rising edge sets", trig_flag, 1);
        hw_trig = 1'b0; tick();
        chk("R3 edge flag latched", trig_flag, 1);
        desc_done = 1'b1; desc_clr_trig = 1'b1; tick();
        desc_done = 1'b0; desc_clr_trig = 1'b0;
        chk("R3 edge flag cleared", trig_flag, 0);
    endtask

    task automatic t_edge_fall();
        reset_dut(32'h0000_0002, 1'b0);
        hw_trig = 1'b1; tick();
        chk("R3 rising ignored in falling mode", trig_flag, 0);
        hw_trig = 1'b0; tick();
        chk("R3 falling edge sets", trig_flag, 1);
    endtask

    task automatic t_level();
        reset_dut(32'h0000_0022, 1'b1);
        tick();
        chk("R4 inactive level", trig_flag, 0);
        pulse_sw();
        chk("R4 sw ignored in level mode", trig_flag, 0);
        hw_trig = 1'b0; tick();
        chk("R4 active low level sets", trig_flag, 1);
        desc_done = 1'b1; desc_clr_trig = 1'b1; tick();
        desc_done = 1'b0; desc_clr_trig = 1'b0;
        chk("R4 clear ignored while asserted", trig_flag, 1);
        hw_trig = 1'b1; tick();
        chk("R4 level released", trig_flag, 0);
    endtask

    task automatic t_periph();
        reset_dut(32'h0000_0001, 1'b0);
        pulse_sw();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 gated by request", go, 0);
        end
        periph_req = 1'b1; tick();
        chk("R5 go once request rises", go, 1);
    endtask

    task automatic t_wrap_burst();
        reset_dut(32'h0000_4240, 1'b0);
        pulse_sw(); tick();
        for (int i = 0; i < 4; i++) begin
            item_done = 1'b1; #1;
            chk("R8 src wrap on block end", src_wrap, (i == 3) ? 1 : 0);
            chk("R8 dst wrap disabled", dst_wrap, 0);
            tick(); item_done = 1'b0;
        end
    endtask

    task automatic t_wrap_single();
        reset_dut(32'h0000_8100, 1'b0);
        item_done = 1'b1; #1;
        chk("R7 idle item ignored", dst_wrap, 0);
        tick(); item_done = 1'b0;
        pulse_sw(); tick();
        chk("R5 single go", go, 1);
        item_done = 1'b1; #1;
        chk("R8 first item no wrap", dst_wrap, 0);
        tick(); item_done = 1'b0;
        tick();
        chk("R7 second go", go, 1);
        item_done = 1'b1; #1;
        chk("R8 dst wrap across single gos", dst_wrap, 1);
        chk("R8 src wrap disabled", src_wrap, 0);
        tick(); item_done = 1'b0;
    endtask

    task automatic t_prio();
        reset_dut(32'h0005_0000, 1'b0);
        #1;
        chk("R9 priority field", chan_prio, 5);
    endtask

    initial begin
        t_reset();
        t_sw_single();
        t_set_strobe();
        t_burst();
        t_clamp();
        t_edge_rise();
        t_edge_fall();
        t_level();
        t_periph();
        t_wrap_burst();
        t_wrap_single();
        t_prio();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule